// File: doc/BRIEF.md
# Serial Receiver with Line-Break Detection

This block receives asynchronous serial frames of eight or nine data bits, least significant bit first, using an oversampling tick supplied from outside. A falling edge seen on a tick starts a frame. The receiver checks that the start bit is still low at its mid-point. It takes each data bit and the stop bit as a majority of three samples around the middle of the bit, and then presents the assembled word with a one-cycle valid pulse.

A separate counter watches the line for long low periods. It runs independently of frame alignment. When the line has been low for eleven bit times, it declares a break. A break sets a sticky break flag and also sets the framing-error flag. It can request a one-cycle reset, and it parks the receiver until the line is seen high again. A bad stop bit on its own sets only the framing-error flag. Both flags clear only through write-one-to-clear strobes. A control-bit output shows either the framing error or a stored mode bit, depending on a select input.

Top module: `uart_brk_rx`

## Requirements
- R1: The line input passes through a two-stage synchronizer. The asynchronous reset is released through two flops. While in reset, all outputs are 0.
- R2: On a tick in idle with the synchronized line low, a start bit begins (that tick is sample 0). If the line is high at sample OVS/2 of the start bit, the receiver returns to idle. No valid pulse and no flag result.
- R3: Each data bit is the majority of samples OVS/2-1, OVS/2 and OVS/2+1 of its bit period, stored least significant bit first. nine_bit=0 receives 8 bits with rx_data[8]=0. nine_bit=1 receives 9 bits.
- R4: At sample OVS/2+1 of the stop bit, rx_valid is high for exactly one clock. rx_data holds the frame, and the receiver returns to idle.
- R5: A stop-bit majority of 0 sets fe_flag. It does not set brk_flag.
- R6: After BRK_BITS*OVS consecutive ticks with the line sampled low, brk_flag is set. Any high sample restarts the count. A single low run declares at most one break.
- R7: A break also sets fe_flag.
- R8: After a break, the receiver produces no frame until a tick sees the line high.
- R9: ctl_b7 shows fe_flag when fe_on_ctl=1. Otherwise it shows the mode bit stored by mode_wr/mode_wd.
- R10: When brk_rst_en=1, rst_req is high for exactly one clock, in the cycle brk_flag first reads 1. When brk_rst_en=0, rst_req stays 0.
- R11: clr_fe and clr_brk clear their flag, and do nothing else. A setting event in the same cycle wins over a clear.
- R12: Without a tick, the receive state does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling tick, OVS per bit |
| rxd | input | 1 | Serial line, idle high |
| nine_bit | input | 1 | 1: nine data bits, 0: eight |
| fe_on_ctl | input | 1 | Select for ctl_b7 |
| mode_wr | input | 1 | Write strobe for stored mode bit |
| mode_wd | input | 1 | Mode bit write data |
| brk_rst_en | input | 1 | Allow reset request on break |
| clr_fe | input | 1 | Write-one-to-clear framing error |
| clr_brk | input | 1 | Write-one-to-clear break flag |
| rx_data | output | DATA_W+1 | Received word |
| rx_valid | output | 1 | One-cycle frame-complete pulse |
| fe_flag | output | 1 | Sticky framing error |
| brk_flag | output | 1 | Sticky break detect |
| ctl_b7 | output | 1 | Control bit 7 view |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with its defaults: OVS=16, DATA_W=8 and BRK_BITS=11. It runs the tick at every clock and at every third clock, so the hold-without-tick behaviour is exercised. With these values an all-zero nine-bit frame with a low stop bit fills exactly the 176-tick break window. In eight-bit mode, a long low line first produces a framing-error frame, then the break, then a parked receiver. The boundary between a framing error and a break is therefore reached with ordinary frames.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_BRKWAIT
  } rx_state_t;
endpackage

// File: rtl/uart_brk_sync.sv
module uart_brk_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/uart_brk_lowcnt.sv
module uart_brk_lowcnt #(
  parameter int OVS      = 16,
  parameter int BRK_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx_s,
  output logic brk_now
);
  localparam int LIMIT = OVS * BRK_BITS;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d   = cnt_q;
    brk_now = 1'b0;
    if (tick) begin
      if (rx_s) begin
        cnt_d = '0;
      end else begin
        if (cnt_q == CW'(LIMIT - 1)) brk_now = 1'b1;
        if (cnt_q < CW'(LIMIT))      cnt_d   = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6: one declaration per low run
  a_r6_single_declare: assert property (@(posedge clk) disable iff (!rst_n)
    brk_now |=> !brk_now);
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIMIT));
endmodule

// File: rtl/uart_brk_frame.sv
module uart_brk_frame
  import uart_brk_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_s,
  input  logic              nine_bit,
  input  logic              brk_now,
  output logic              stop_bad,
  output logic              valid_q,
  output logic [DATA_W:0]   data_q
);
  localparam int NW  = DATA_W + 1;
  localparam int PW  = $clog2(OVS);
  localparam int IW  = $clog2(NW + 1);
  localparam int MID = OVS / 2;

  rx_state_t       state_q, state_d;
  logic [PW-1:0]   ph_q, ph_d;
  logic [IW-1:0]   idx_q, idx_d;
  logic [1:0]      v_q, v_d;
  logic [NW-1:0]   data_d;
  logic            valid_d;
  logic            maj;
  logic [IW-1:0]   last_idx;

  assign maj      = (v_q[0] & v_q[1]) | (v_q[0] & rx_s) | (v_q[1] & rx_s);
  assign last_idx = nine_bit ? IW'(NW - 1) : IW'(NW - 2);

  always_comb begin
    state_d  = state_q;
    ph_d     = ph_q;
    idx_d    = idx_q;
    v_d      = v_q;
    data_d   = data_q;
    valid_d  = 1'b0;
    stop_bad = 1'b0;
    if (tick) begin
      if (state_q == ST_DATA || state_q == ST_STOP) begin
        if (ph_q == PW'(MID - 1)) v_d[0] = rx_s;
        if (ph_q == PW'(MID))     v_d[1] = rx_s;
      end
      if (brk_now) begin
        state_d = ST_BRKWAIT;
      end else begin
        unique case (state_q)
          ST_IDLE: if (!rx_s) begin
            state_d = ST_START;
            ph_d    = PW'(1);
            data_d  = '0;
          end
          ST_START: begin
            if (ph_q == PW'(MID) && rx_s) begin
              state_d = ST_IDLE;
            end else if (ph_q == PW'(OVS - 1)) begin
              state_d = ST_DATA;
              ph_d    = '0;
              idx_d   = '0;
            end else begin
              ph_d = ph_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (ph_q == PW'(MID + 1)) data_d[idx_q] = maj;
            if (ph_q == PW'(OVS - 1)) begin
              ph_d = '0;
              if (idx_q == last_idx) state_d = ST_STOP;
              else                   idx_d   = idx_q + 1'b1;
            end else begin
              ph_d = ph_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (ph_q == PW'(MID + 1)) begin
              valid_d  = 1'b1;
              stop_bad = ~maj;
              state_d  = ST_IDLE;
            end else begin
              ph_d = ph_q + 1'b1;
            end
          end
          ST_BRKWAIT: if (rx_s) state_d = ST_IDLE;
          default: state_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      idx_q   <= '0;
      v_q     <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      idx_q   <= idx_d;
      v_q     <= v_d;
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

  a_r12_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(state_q) && $stable(ph_q));
  a_r8_parked_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BRKWAIT && !rx_s) |=> state_q == ST_BRKWAIT);
  a_r4_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  a_r2_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && tick && rx_s && ph_q == PW'(MID) && !brk_now)
      |=> state_q == ST_IDLE && !valid_q);
  a_r3_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IW'(NW - 1));
endmodule

// File: rtl/uart_brk_status.sv
module uart_brk_status (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_now,
  input  logic stop_bad,
  input  logic clr_fe,
  input  logic clr_brk,
  input  logic brk_rst_en,
  input  logic fe_on_ctl,
  input  logic mode_wr,
  input  logic mode_wd,
  output logic fe_flag,
  output logic brk_flag,
  output logic rst_req,
  output logic ctl_b7
);
  logic fe_q, fe_d, brk_q, brk_d, req_q, req_d, sm_q, sm_d;

  always_comb begin
    fe_d  = (brk_now | stop_bad) ? 1'b1 : (clr_fe ? 1'b0 : fe_q);
    brk_d = brk_now ? 1'b1 : (clr_brk ? 1'b0 : brk_q);
    req_d = brk_now & brk_rst_en;
    sm_d  = mode_wr ? mode_wd : sm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fe_q  <= 1'b0;
      brk_q <= 1'b0;
      req_q <= 1'b0;
      sm_q  <= 1'b0;
    end else begin
      fe_q  <= fe_d;
      brk_q <= brk_d;
      req_q <= req_d;
      sm_q  <= sm_d;
    end
  end

  assign fe_flag  = fe_q;
  assign brk_flag = brk_q;
  assign rst_req  = req_q;
  assign ctl_b7   = fe_on_ctl ? fe_q : sm_q;

  a_r11_fe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_q && !clr_fe) |=> fe_q);
  a_r11_brk_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_q && !clr_brk) |=> brk_q);
  a_r10_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
  a_r10_req_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> brk_q);
  a_r7_break_sets_fe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_q) |-> fe_q);
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx #(
  parameter int OVS      = 16,
  parameter int DATA_W   = 8,
  parameter int BRK_BITS = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              nine_bit,
  input  logic              fe_on_ctl,
  input  logic              mode_wr,
  input  logic              mode_wd,
  input  logic              brk_rst_en,
  input  logic              clr_fe,
  input  logic              clr_brk,
  output logic [DATA_W:0]   rx_data,
  output logic              rx_valid,
  output logic              fe_flag,
  output logic              brk_flag,
  output logic              ctl_b7,
  output logic              rst_req
);
  logic [1:0] rq_q;
  logic       rst_int_n;
  logic       rx_s;
  logic       brk_now;
  logic       stop_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rq_q <= 2'b00;
    else        rq_q <= {rq_q[0], 1'b1};
  end
  assign rst_int_n = rq_q[1];

  uart_brk_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d(rxd), .q(rx_s)
  );

  uart_brk_lowcnt #(.OVS(OVS), .BRK_BITS(BRK_BITS)) u_lowcnt (
    .clk(clk), .rst_n(rst_int_n), .tick(os_tick), .rx_s(rx_s), .brk_now(brk_now)
  );

  uart_brk_frame #(.OVS(OVS), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_int_n), .tick(os_tick), .rx_s(rx_s),
    .nine_bit(nine_bit), .brk_now(brk_now), .stop_bad(stop_bad),
    .valid_q(rx_valid), .data_q(rx_data)
  );

  uart_brk_status u_status (
    .clk(clk), .rst_n(rst_int_n), .brk_now(brk_now), .stop_bad(stop_bad),
    .clr_fe(clr_fe), .clr_brk(clr_brk), .brk_rst_en(brk_rst_en),
    .fe_on_ctl(fe_on_ctl), .mode_wr(mode_wr), .mode_wd(mode_wd),
    .fe_flag(fe_flag), .brk_flag(brk_flag), .rst_req(rst_req), .ctl_b7(ctl_b7)
  );

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_int_n |-> !rx_valid && !fe_flag && !brk_flag && !rst_req);
endmodule

// File: tb/uart_brk_rx_bench.sv
`timescale 1ns/1ps
module uart_brk_rx_bench;
  localparam int OVS = 16;
  localparam int BRKT = 16 * 11;

  logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0, rxd = 1'b1;
  logic nine_bit = 1'b0, fe_on_ctl = 1'b0, mode_wr = 1'b0, mode_wd = 1'b0;
  logic brk_rst_en = 1'b0, clr_fe = 1'b0, clr_brk = 1'b0;
  logic [8:0] rx_data;
  logic rx_valid, fe_flag, brk_flag, ctl_b7, rst_req;

  int n_chk = 0, n_fail = 0, nvalid = 0, nreq = 0, last_data = 0;
  int tick_div = 1, tk = 0;
  bit cmp_en = 0, done = 0;

  always #2 clk = ~clk;

  uart_brk_rx u_uart_brk_rx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd), .nine_bit(nine_bit),
    .fe_on_ctl(fe_on_ctl), .mode_wr(mode_wr), .mode_wd(mode_wd),
    .brk_rst_en(brk_rst_en), .clr_fe(clr_fe), .clr_brk(clr_brk),
    .rx_data(rx_data), .rx_valid(rx_valid), .fe_flag(fe_flag),
    .brk_flag(brk_flag), .ctl_b7(ctl_b7), .rst_req(rst_req)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_rq1, m_rq2, m_s1, m_s2, m_st, m_ph, m_idx, m_v7, m_v8, m_data, m_lc;
  int m_valid, m_fe, m_brk, m_req, m_sm0;

  task automatic m_clear();
    m_s1 = 1; m_s2 = 1; m_st = 0; m_ph = 0; m_idx = 0; m_v7 = 0; m_v8 = 0;
    m_data = 0; m_lc = 0; m_valid = 0; m_fe = 0; m_brk = 0; m_req = 0; m_sm0 = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rq1 = 0; m_rq2 = 0; m_clear();
    end else begin
      int old_rq, rs, bk, bad, maj, last;
      old_rq = m_rq2; m_rq2 = m_rq1; m_rq1 = 1;
      if (old_rq == 0) m_clear();
      else begin
        rs = m_s2; m_s2 = m_s1; m_s1 = rxd;
        bk = 0; bad = 0; m_valid = 0;
        last = nine_bit ? 8 : 7;
        if (os_tick) begin
          if (rs != 0) m_lc = 0;
          else begin
            if (m_lc == BRKT - 1) bk = 1;
            if (m_lc < BRKT) m_lc++;
          end
          maj = (m_v7 + m_v8 + rs) >= 2;
          if ((m_st == 2 || m_st == 3) && m_ph == 7) m_v7 = rs;
          if ((m_st == 2 || m_st == 3) && m_ph == 8) m_v8 = rs;
          if (bk) m_st = 4;
          else case (m_st)
            0: if (rs == 0) begin m_st = 1; m_ph = 1; m_data = 0; end
            1: if (m_ph == 8 && rs != 0) m_st = 0;
               else if (m_ph == 15) begin m_st = 2; m_ph = 0; m_idx = 0; end
               else m_ph++;
            2: begin
                 if (m_ph == 9) m_data = m_data | (maj << m_idx);
                 if (m_ph == 15) begin
                   m_ph = 0;
                   if (m_idx == last) m_st = 3; else m_idx++;
                 end else m_ph++;
               end
            3: if (m_ph == 9) begin m_valid = 1; bad = !maj; m_st = 0; end
               else m_ph++;
            default: if (rs != 0) m_st = 0;
          endcase
        end
        if (bk || bad) m_fe = 1; else if (clr_fe) m_fe = 0;
        if (bk) m_brk = 1; else if (clr_brk) m_brk = 0;
        m_req = bk & brk_rst_en;
        if (mode_wr) m_sm0 = mode_wd;
      end
    end
  end

  // tick generator, monitor and every-cycle comparison
  always @(negedge clk) begin
    os_tick = (tk == tick_div - 1);
    tk = (tk + 1) % tick_div;
    if (rx_valid) begin nvalid++; last_data = rx_data; end
    if (rst_req) nreq++;
    if (cmp_en) begin
      chk("R4 rx_valid vs model", rx_valid, m_valid);
      if (rx_valid) chk("R3 rx_data vs model", rx_data, m_data);
      chk("R5 fe_flag vs model", fe_flag, m_fe);
      chk("R6 brk_flag vs model", brk_flag, m_brk);
      chk("R9 ctl_b7 vs model", ctl_b7, fe_on_ctl ? m_fe : m_sm0);
      chk("R10 rst_req vs model", rst_req, m_req);
    end
  end

  task automatic hold(int n);
    int c = 0;
    while (c < n) begin @(posedge clk); if (os_tick) c++; end
    @(negedge clk);
  endtask

  task automatic send(int d, int nb, bit stopv);
    rxd = 0; hold(OVS);
    for (int i = 0; i < nb; i++) begin rxd = d[i]; hold(OVS); end
    rxd = stopv; hold(OVS);
    rxd = 1; hold(2 * OVS);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_fe = 1; clr_brk = 1;
    @(negedge clk); clr_fe = 0; clr_brk = 0;
    @(negedge clk);
  endtask

  initial begin
    int nv, nr;
    repeat (5) @(negedge clk);
    chk("R1 rx_valid in reset", rx_valid, 0);
    chk("R1 fe_flag in reset", fe_flag, 0);
    chk("R1 brk_flag in reset", brk_flag, 0);
    rst_n = 1;
    repeat (6) @(negedge clk);
    cmp_en = 1;

    // R3 R4 eight-bit frames
    nv = nvalid; send('hA5, 8, 1);
    chk("R4 one valid per frame", nvalid - nv, 1);
    chk("R3 data A5", last_data, 'hA5);
    send('h3C, 8, 1);
    chk("R3 data 3C", last_data, 'h3C);
    chk("R5 no fe on good stop", fe_flag, 0);

    // R3 nine-bit frame
    nine_bit = 1; send('h1A5, 9, 1);
    chk("R3 nine-bit data", last_data, 'h1A5);
    nine_bit = 0;

    // R3 single-tick glitch mid-bit is outvoted
    rxd = 0; hold(OVS);
    for (int i = 0; i < 8; i++) begin
      rxd = i[0]; hold(7); rxd = ~i[0]; hold(1); rxd = i[0]; hold(OVS - 8);
    end
    rxd = 1; hold(3 * OVS);
    chk("R3 glitch outvoted", last_data, 'hAA);

    // R2 false start
    nv = nvalid; rxd = 0; hold(5); rxd = 1; hold(4 * OVS);
    chk("R2 false start gives no frame", nvalid - nv, 0);
    chk("R2 false start gives no fe", fe_flag, 0);

    // R5 bad stop
    send('h5A, 8, 0);
    chk("R5 fe on low stop", fe_flag, 1);
    chk("R5 no break on low stop", brk_flag, 0);
    chk("R4 data with bad stop", last_data, 'h5A);

    // R9 control-bit view
    @(negedge clk); fe_on_ctl = 1; @(negedge clk);
    chk("R9 ctl shows fe", ctl_b7, 1);
    fe_on_ctl = 0; mode_wr = 1; mode_wd = 0; @(negedge clk); mode_wr = 0; @(negedge clk);
    chk("R9 ctl shows mode bit 0", ctl_b7, 0);
    mode_wr = 1; mode_wd = 1; @(negedge clk); mode_wr = 0; @(negedge clk);
    chk("R9 ctl shows mode bit 1", ctl_b7, 1);

    // R11 clear
    pulse_clr();
    chk("R11 fe cleared", fe_flag, 0);
    chk("R11 clear leaves mode bit", ctl_b7, 1);

    // R6 R7 R10 R8 break with reset request
    brk_rst_en = 1; nr = nreq;
    rxd = 0; hold(BRKT + 2 * OVS);
    chk("R6 break flag", brk_flag, 1);
    chk("R7 break sets fe", fe_flag, 1);
    chk("R10 one reset request", nreq - nr, 1);
    nv = nvalid; hold(3 * OVS);
    chk("R8 no frame while parked", nvalid - nv, 0);
    rxd = 1; hold(2 * OVS);
    send('h33, 8, 1);
    chk("R8 frame after release", last_data, 'h33);
    chk("R11 brk sticky", brk_flag, 1);

    // R10 disabled request, R6 nine-bit all-zero frame reaches break
    pulse_clr(); brk_rst_en = 0; nr = nreq;
    nine_bit = 1; send(0, 9, 0);
    chk("R6 all-zero nine-bit frame breaks", brk_flag, 1);
    chk("R10 no request when disabled", nreq - nr, 0);
    nine_bit = 0; pulse_clr();

    // R12 slow tick
    tick_div = 3; hold(4);
    send('hC3, 8, 1);
    chk("R12 slow tick data", last_data, 'hC3);
    send('h7E, 8, 1);
    chk("R12 slow tick data 2", last_data, 'h7E);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R12 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule